// File: doc/BRIEF.md
# Buffer Ownership Semaphore

This block decides which of two parties may touch a shared pair of transmit and receive buffers: the CPU or an SPI slave transaction engine. The CPU asks for the buffers with a one-cycle acquire strobe and hands them back with a one-cycle release strobe. The slave engine reports a chip-select level and a one-cycle end-of-transaction strobe. The block returns a grant to the slave engine and a 2-bit ownership code.

Two sticky event flags record two things: the CPU has gained ownership, and a granted slave transaction has finished. Software clears each flag with its own strobe. An interrupt enable mask is written through separate set and clear strobes. The interrupt line is high while any enabled flag is set.

A CPU acquire that arrives while a granted slave transaction is running is not lost. It is queued in a handover state and served when that transaction ends. An optional shortcut input turns every transaction end into an acquire, so the CPU regains the buffers without further action.

Top module: `spi_buf_sema`

## Requirements
- R1: After reset, the ownership code is 0, the grant is low, both event flags are clear, the enable mask is 0 and the interrupt is low. The ownership code encodings are 0 free, 1 CPU, 2 slave, 3 slave with handover to the CPU pending.
- R2: An acquire strobe in the free state moves the code to 1 on the next clock and sets the acquired flag. This holds even when chip-select is asserted in the same cycle.
- R3: An acquire strobe while the code is 1 sets the acquired flag again and leaves the code at 1.
- R4: A release strobe while the code is 1 moves the code to 0 on the next clock, and wins over an acquire in the same cycle. A release strobe in any other state has no effect.
- R5: Chip-select asserted in the free state moves the code to 2. The slave grant is high exactly while the code is 2 or 3.
- R6: An acquire strobe while the code is 2 moves the code to 3. A transaction end while the code is 3 moves the code to 1 and sets both the end flag and the acquired flag. An acquire and an end together in state 2 have the same result.
- R7: A transaction end in state 2 sets the end flag. With the shortcut input low, the code then goes to 0. With it high, the code goes to 1 and the acquired flag is set.
- R8: A transaction end while the code is 0 or 1 sets no end flag. Chip-select while the code is 1 does not raise the grant or change the code.
- R9: An event flag stays set until its clear strobe. If a set and a clear of the same flag land in one cycle, the flag ends up set.
- R10: Mask bit 0 enables the end flag and bit 1 enables the acquired flag. A set write ORs the write data into the mask. A clear write removes the written bits. When both writes happen in one cycle, the clear wins for the bits it names.
- R11: The interrupt equals the OR, over both flags, of the flag ANDed with its mask bit. It follows changes in the flags and in the mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| task_acquire | input | 1 | CPU acquire strobe, one cycle |
| task_release | input | 1 | CPU release strobe, one cycle |
| cs_active | input | 1 | Slave chip-select asserted (level) |
| xfer_end | input | 1 | Slave transaction finished, one cycle |
| short_end_acq | input | 1 | Turn every granted end into an acquire |
| clr_end_evt | input | 1 | Clear the end flag |
| clr_acq_evt | input | 1 | Clear the acquired flag |
| ie_set_wr | input | 1 | OR ie_wdata into the enable mask |
| ie_clr_wr | input | 1 | Remove ie_wdata bits from the enable mask |
| ie_wdata | input | 2 | Enable write data (bit 0 end, bit 1 acquired) |
| ie_mask | output | 2 | Current enable mask |
| own_state | output | 2 | Ownership code |
| evt_end | output | 1 | End event flag |
| evt_acquired | output | 1 | Acquired event flag |
| slave_grant | output | 1 | Slave engine may use the buffers |
| irq | output | 1 | Interrupt request |

## Verification
The properties do not require the strobes to be one cycle wide, and they do not require chip-select to be consistent with the end strobe. Each property follows the code and flags only from the cycle after the inputs it names are sampled, so any input combination is legal for them. The directed part of the stimulus uses single-cycle strobes and realistic slave sequences. A later random phase drives arbitrary combinations, including overlapping acquire, release and end, and it stays within these properties because none of them assumes an input protocol.

// File: rtl/spi_sema_pkg.sv
// Shared types for the buffer ownership semaphore.
// Assumes nothing; holds only encodings and event indices.
package spi_sema_pkg;
    typedef enum logic [1:0] {
        OWN_FREE    = 2'd0,
        OWN_CPU     = 2'd1,
        OWN_SLAVE   = 2'd2,
        OWN_HANDOFF = 2'd3
    } own_t;

    localparam int EVT_W   = 2;
    localparam int EVT_END = 0;
    localparam int EVT_ACQ = 1;
endpackage

// File: rtl/sema_owner_fsm.sv
// Ownership state machine: tracks who holds the buffers and emits
// one-cycle set pulses for the end and acquired events.
// Assumes strobes are sampled on the rising clock; any width is tolerated.
module sema_owner_fsm
    import spi_sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acq,
    input  logic rel,
    input  logic cs,
    input  logic done,
    input  logic short_en,
    output own_t state,
    output logic set_acq,
    output logic set_end
);
    own_t nxt;

    // Next ownership and event pulses from current owner and inputs.
    always_comb begin
        nxt     = state;
        set_acq = 1'b0;
        set_end = 1'b0;
        unique case (state)
            OWN_FREE: begin
                if (acq) begin
                    nxt     = OWN_CPU;
                    set_acq = 1'b1;
                end else if (cs) begin
                    nxt = OWN_SLAVE;
                end
            end
            OWN_CPU: begin
                if (rel) begin
                    nxt = OWN_FREE;
                end else if (acq) begin
                    set_acq = 1'b1;
                end
            end
            OWN_SLAVE: begin
                if (done) begin
                    set_end = 1'b1;
                    if (acq || short_en) begin
                        nxt     = OWN_CPU;
                        set_acq = 1'b1;
                    end else begin
                        nxt = OWN_FREE;
                    end
                end else if (acq) begin
                    nxt = OWN_HANDOFF;
                end
            end
            OWN_HANDOFF: begin
                if (done) begin
                    set_end = 1'b1;
                    set_acq = 1'b1;
                    nxt     = OWN_CPU;
                end
            end
            default: nxt = OWN_FREE;
        endcase
    end

    // Ownership register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OWN_FREE;
        else        state <= nxt;
    end
endmodule

// File: rtl/sema_evt_flags.sv
// Sticky event flags: each bit is set by hardware and cleared by software.
// A set in the same cycle as a clear leaves the bit set.
module sema_evt_flags #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    for (genvar g = 0; g < W; g++) begin : g_flag
        // One sticky bit; set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_o[g] <= 1'b0;
            else if (set_i[g])   flag_o[g] <= 1'b1;
            else if (clr_i[g])   flag_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/sema_irq_ctl.sv
// Interrupt enable mask with set/clear writes and the combined request.
// Assumes flag_i is registered upstream; irq is combinational from it.
module sema_irq_ctl #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] flag_i,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    // Qualify write data by the write strobes.
    always_comb begin
        set_bits = set_wr ? wdata : '0;
        clr_bits = clr_wr ? wdata : '0;
    end

    // Mask register; clear wins over set for the same bit.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_o <= '0;
        else        mask_o <= (mask_o | set_bits) & ~clr_bits;
    end

    // Request is any enabled, pending flag.
    always_comb irq_o = |(flag_i & mask_o);
endmodule

// File: rtl/spi_buf_sema.sv
// Top of the buffer ownership semaphore between the CPU and an SPI slave.
// Assumes a single clock domain; slave-side inputs are already synchronised.
module spi_buf_sema
    import spi_sema_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             task_acquire,
    input  logic             task_release,
    input  logic             cs_active,
    input  logic             xfer_end,
    input  logic             short_end_acq,
    input  logic             clr_end_evt,
    input  logic             clr_acq_evt,
    input  logic             ie_set_wr,
    input  logic             ie_clr_wr,
    input  logic [EVT_W-1:0] ie_wdata,
    output logic [EVT_W-1:0] ie_mask,
    output logic [1:0]       own_state,
    output logic             evt_end,
    output logic             evt_acquired,
    output logic             slave_grant,
    output logic             irq
);
    own_t             state;
    logic             set_acq;
    logic             set_end;
    logic [EVT_W-1:0] evt_set;
    logic [EVT_W-1:0] evt_clr;
    logic [EVT_W-1:0] evt_flag;

    sema_owner_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .acq      (task_acquire),
        .rel      (task_release),
        .cs       (cs_active),
        .done     (xfer_end),
        .short_en (short_end_acq),
        .state    (state),
        .set_acq  (set_acq),
        .set_end  (set_end)
    );

    // Route event pulses and clear strobes into the flag vector.
    always_comb begin
        evt_set          = '0;
        evt_clr          = '0;
        evt_set[EVT_END] = set_end;
        evt_set[EVT_ACQ] = set_acq;
        evt_clr[EVT_END] = clr_end_evt;
        evt_clr[EVT_ACQ] = clr_acq_evt;
    end

    sema_evt_flags #(.W(EVT_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .flag_o (evt_flag)
    );

    sema_irq_ctl #(.W(EVT_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (ie_set_wr),
        .clr_wr (ie_clr_wr),
        .wdata  (ie_wdata),
        .flag_i (evt_flag),
        .mask_o (ie_mask),
        .irq_o  (irq)
    );

    // Drive the port-level views of state and flags.
    always_comb begin
        own_state    = state;
        slave_grant  = (state == OWN_SLAVE) || (state == OWN_HANDOFF);
        evt_end      = evt_flag[EVT_END];
        evt_acquired = evt_flag[EVT_ACQ];
    end
endmodule

// File: rtl/sema_chk.sv
// Port-level properties of the ownership semaphore, bound to the top.
// Assumes only the synchronous active-low reset; no input protocol.
module sema_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       task_acquire,
    input logic       task_release,
    input logic       cs_active,
    input logic       xfer_end,
    input logic       clr_acq_evt,
    input logic       ie_set_wr,
    input logic       ie_clr_wr,
    input logic [1:0] ie_wdata,
    input logic [1:0] ie_mask,
    input logic [1:0] own_state,
    input logic       evt_end,
    input logic       evt_acquired,
    input logic       slave_grant,
    input logic       irq
);
    a_r2_free_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        (own_state == 2'd0 && task_acquire) |=> (own_state == 2'd1 && evt_acquired));

    a_r4_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (own_state == 2'd1 && task_release) |=> (own_state == 2'd0));

    a_r6_handoff_done: assert property (@(posedge clk) disable iff (!rst_n)
        (own_state == 2'd3 && xfer_end) |=> (own_state == 2'd1 && evt_acquired && evt_end));

    a_r8_cpu_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (own_state == 2'd1 && cs_active) |=> !slave_grant);

    a_r8_ungranted_no_end: assert property (@(posedge clk) disable iff (!rst_n)
        (own_state[1] == 1'b0 && xfer_end && !evt_end) |=> !evt_end);

    a_r9_acq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_acquired && !clr_acq_evt) |=> evt_acquired);

    a_r10_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_set_wr && !ie_clr_wr) |=> ((ie_mask & $past(ie_wdata)) == $past(ie_wdata)));

    a_r11_irq_combine: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((evt_end & ie_mask[0]) | (evt_acquired & ie_mask[1])));
endmodule

bind spi_buf_sema sema_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_acquire (task_acquire),
    .task_release (task_release),
    .cs_active    (cs_active),
    .xfer_end     (xfer_end),
    .clr_acq_evt  (clr_acq_evt),
    .ie_set_wr    (ie_set_wr),
    .ie_clr_wr    (ie_clr_wr),
    .ie_wdata     (ie_wdata),
    .ie_mask      (ie_mask),
    .own_state    (own_state),
    .evt_end      (evt_end),
    .evt_acquired (evt_acquired),
    .slave_grant  (slave_grant),
    .irq          (irq)
);

// File: tb/spi_buf_sema_bench.sv
// Bench: directed scenarios plus a random phase, with a behavioural
// reference model that is compared against every output on every clock.
module spi_buf_sema_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       task_acquire = 0, task_release = 0, cs_active = 0, xfer_end = 0;
    logic       short_end_acq = 0, clr_end_evt = 0, clr_acq_evt = 0;
    logic       ie_set_wr = 0, ie_clr_wr = 0;
    logic [1:0] ie_wdata = 0;
    logic [1:0] ie_mask, own_state;
    logic       evt_end, evt_acquired, slave_grant, irq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int m_own = 0;
    bit m_end = 0, m_acq = 0;
    int m_mask = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_buf_sema u_spi_buf_sema (
        .clk(clk), .rst_n(rst_n), .task_acquire(task_acquire),
        .task_release(task_release), .cs_active(cs_active), .xfer_end(xfer_end),
        .short_end_acq(short_end_acq), .clr_end_evt(clr_end_evt),
        .clr_acq_evt(clr_acq_evt), .ie_set_wr(ie_set_wr), .ie_clr_wr(ie_clr_wr),
        .ie_wdata(ie_wdata), .ie_mask(ie_mask), .own_state(own_state),
        .evt_end(evt_end), .evt_acquired(evt_acquired),
        .slave_grant(slave_grant), .irq(irq)
    );

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        bit se, sa;
        int nxt;
        se = 0; sa = 0; nxt = m_own;
        if (!rst_n) begin
            m_own = 0; m_end = 0; m_acq = 0; m_mask = 0;
        end else begin
            if (m_own == 0) begin
                if (task_acquire) begin nxt = 1; sa = 1; end
                else if (cs_active) nxt = 2;
            end else if (m_own == 1) begin
                if (task_release) nxt = 0;
                else if (task_acquire) sa = 1;
            end else if (m_own == 2) begin
                if (xfer_end) begin
                    se = 1;
                    if (task_acquire || short_end_acq) begin nxt = 1; sa = 1; end
                    else nxt = 0;
                end else if (task_acquire) nxt = 3;
            end else begin
                if (xfer_end) begin se = 1; sa = 1; nxt = 1; end
            end
            m_end  = se ? 1'b1 : (clr_end_evt ? 1'b0 : m_end);
            m_acq  = sa ? 1'b1 : (clr_acq_evt ? 1'b0 : m_acq);
            if (ie_set_wr) m_mask = m_mask | int'(ie_wdata);
            if (ie_clr_wr) m_mask = m_mask & ~int'(ie_wdata);
            m_own = nxt;
        end
    end

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    task automatic compare_all();
        bit m_irq;
        m_irq = (m_end && m_mask[0]) || (m_acq && m_mask[1]);
        check("R1 own_state", int'(own_state), m_own);
        check("R5 slave_grant", int'(slave_grant), int'(m_own >= 2));
        check("R9 evt_end", int'(evt_end), int'(m_end));
        check("R9 evt_acquired", int'(evt_acquired), int'(m_acq));
        check("R10 ie_mask", int'(ie_mask), m_mask & 3);
        check("R11 irq", int'(irq), int'(m_irq));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        task_acquire = 0; task_release = 0; xfer_end = 0;
        clr_end_evt = 0; clr_acq_evt = 0; ie_set_wr = 0; ie_clr_wr = 0;
        ie_wdata = 0;
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check("R1 reset code", int'(own_state), 0);
        check("R1 reset grant", int'(slave_grant), 0);
        check("R1 reset flags", int'({evt_end, evt_acquired}), 0);
        check("R1 reset mask/irq", int'({ie_mask, irq}), 0);

        // R2 acquire in free beats chip-select
        task_acquire = 1; cs_active = 1; tick(); idle();
        check("R2 free acquire code", int'(own_state), 1);
        check("R2 acquired flag", int'(evt_acquired), 1);

        // R9 clear, then R3 acquire while owned
        clr_acq_evt = 1; tick(); idle();
        check("R9 flag cleared", int'(evt_acquired), 0);
        task_acquire = 1; tick(); idle();
        check("R3 re-acquire code", int'(own_state), 1);
        check("R3 re-acquire flag", int'(evt_acquired), 1);

        // R8 chip-select and end while CPU owns
        xfer_end = 1; tick(); idle();
        check("R8 no grant under CPU", int'(slave_grant), 0);
        check("R8 no end when ungranted", int'(evt_end), 0);
        cs_active = 0;

        // R4 release wins over acquire; release in free is ignored
        task_release = 1; task_acquire = 1; tick(); idle();
        check("R4 release wins", int'(own_state), 0);
        task_release = 1; tick(); idle();
        check("R4 release in free ignored", int'(own_state), 0);

        // R5 slave takes free semaphore; R4 release ignored there
        cs_active = 1; tick(); idle();
        check("R5 slave owns", int'(own_state), 2);
        check("R5 grant high", int'(slave_grant), 1);
        task_release = 1; tick(); idle();
        check("R4 release in slave ignored", int'(own_state), 2);

        // R6 queued handover
        clr_acq_evt = 1; tick(); idle();
        task_acquire = 1; tick(); idle();
        check("R6 handoff pending", int'(own_state), 3);
        check("R6 grant while pending", int'(slave_grant), 1);
        check("R6 no acquire yet", int'(evt_acquired), 0);
        xfer_end = 1; tick(); idle();
        check("R6 handover code", int'(own_state), 1);
        check("R6 end flag", int'(evt_end), 1);
        check("R6 acquired flag", int'(evt_acquired), 1);
        cs_active = 0;

        // R10 mask writes, R11 interrupt
        clr_acq_evt = 1; clr_end_evt = 1; tick(); idle();
        ie_set_wr = 1; ie_wdata = 2'b01; tick(); idle();
        ie_set_wr = 1; ie_wdata = 2'b10; tick(); idle();
        check("R10 set ORs bits", int'(ie_mask), 3);
        check("R11 no flags no irq", int'(irq), 0);
        ie_clr_wr = 1; ie_wdata = 2'b01; tick(); idle();
        check("R10 clear removes bit", int'(ie_mask), 2);
        ie_set_wr = 1; ie_clr_wr = 1; ie_wdata = 2'b01; tick(); idle();
        check("R10 clear wins", int'(ie_mask), 2);
        task_acquire = 1; tick(); idle();
        check("R11 enabled flag raises irq", int'(irq), 1);
        ie_clr_wr = 1; ie_wdata = 2'b10; tick(); idle();
        check("R11 mask drop lowers irq", int'(irq), 0);

        // R7 end without shortcut returns to free
        task_release = 1; tick(); idle();
        clr_acq_evt = 1; cs_active = 1; tick(); idle();
        xfer_end = 1; cs_active = 0; tick(); idle();
        check("R7 no shortcut to free", int'(own_state), 0);
        check("R7 end flag", int'(evt_end), 1);
        check("R7 no acquire", int'(evt_acquired), 0);

        // R7 shortcut, with R9 set beating clear
        cs_active = 1; tick(); idle();
        short_end_acq = 1; xfer_end = 1; clr_end_evt = 1; tick(); idle();
        check("R7 shortcut grants CPU", int'(own_state), 1);
        check("R7 shortcut acquired", int'(evt_acquired), 1);
        check("R9 set beats clear", int'(evt_end), 1);
        short_end_acq = 0; cs_active = 0;

        // Random phase, compared each cycle by the model.
        for (int i = 0; i < 600; i++) begin
            task_acquire  = ($urandom % 6) == 0;
            task_release  = ($urandom % 6) == 0;
            xfer_end      = ($urandom % 5) == 0;
            cs_active     = ($urandom % 3) != 0;
            short_end_acq = ($urandom % 4) == 0;
            clr_end_evt   = ($urandom % 5) == 0;
            clr_acq_evt   = ($urandom % 5) == 0;
            ie_set_wr     = ($urandom % 4) == 0;
            ie_clr_wr     = ($urandom % 5) == 0;
            ie_wdata      = 2'($urandom);
            tick();
        end
        idle();
        tick();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule